// File: doc/BRIEF.md
# Wormhole Output-Port Allocator and Switch

This block is the switching stage in front of one output of a network-on-chip router. Several input buffers present flits on valid/ready streams. A round-robin arbiter picks which waiting packet head may claim the output. The winning input then owns the output until its tail flit has passed. Flits from any other input are masked before they reach the arbiter, so a packet's flits are never interleaved with another packet's flits.

The selected flit is multiplexed into a two-entry elastic buffer that feeds the link. Allocation state changes when a flit enters that buffer, not when it leaves toward the link. Because the buffer decides whether it can accept a flit only from its own occupancy, the arbitration and multiplexing path is timed separately from the link handshake.

Back-pressure rules are as follows. On each input, a flit moves on a clock edge where that input's valid and ready are both high. An input whose ready is low must keep the same flit presented. On the output, a flit moves on an edge where out_valid and out_ready are both high. While out_ready is low, out_valid and out_flit hold their values.

Top module: `wh_out_alloc`

## Requirements
- R1: Each flit carries a kind field in its two most significant bits: 00 body, 01 head, 10 tail, 11 single-flit packet. A head or single flit can be accepted only while no packet owns the output and the elastic buffer holds fewer than two flits.
- R2: At most one bit of in_ready is high in any cycle, and only for an input whose valid is high. Inputs that do not get ready keep their flit.
- R3: Arbitration is round-robin. The search starts at the input after the last granted one and wraps past the highest index.
- R4: Once a head flit from input i has been accepted, no other input receives ready until input i's tail flit has been accepted.
- R5: Body and tail flits from the owning input are accepted in every cycle where they are valid and the buffer has room. A body or tail flit offered while the output is free is never accepted.
- R6: A tail or single flit frees the output at the same edge at which it is accepted. A head waiting at another input can be accepted in the very next cycle.
- R7: While a packet is in flight, round-robin priority stays just after the owner. When the packet ends, the first waiting input after the owner, in round-robin order, wins.
- R8: The elastic buffer holds two flits and keeps them in order. out_valid is high whenever it holds a flit, and out_flit stays stable while out_ready is low. A flit accepted at one edge is presented after that edge. The buffer's input side depends only on how many flits it holds.
- R9: After reset the buffer is empty, no packet owns the output, and priority starts at input 0.
- R10: The output stream equals the accepted flits, unchanged, in the order in which they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | N_IN | Per-input flit valid |
| in_ready | output | N_IN | Per-input ready; one-hot or zero |
| in_flit | input | N_IN*(DATA_W+2) | Input flits, packed, input 0 in the low bits |
| out_valid | output | 1 | Elastic buffer holds a flit |
| out_ready | input | 1 | Link accepts the presented flit |
| out_flit | output | DATA_W+2 | Flit toward the link |

## Verification
A wrong owner bit or availability flag appears at once at in_ready. Ready can go to an input that should be masked, or it can be withheld from an owner's body flit, in the same cycle that the state goes wrong. An off-by-one round-robin pointer only shows when several heads are waiting. The wrong order then appears on out_flit one cycle after the grant. A miscounted buffer appears as either a lost or duplicated flit, or as ready being withheld too early. This shows within the two cycles that it takes to fill the buffer under back-pressure.

// File: rtl/wh_pkg.sv
package wh_pkg;
  // Kind field: bit 0 marks the start of a packet, bit 1 marks its end.
  typedef enum logic [1:0] {
    FK_BODY = 2'b00,
    FK_HEAD = 2'b01,
    FK_TAIL = 2'b10,
    FK_SOLO = 2'b11
  } flit_kind_e;

  function automatic logic kind_opens(logic [1:0] k);
    return k[0];
  endfunction

  function automatic logic kind_closes(logic [1:0] k);
    return k[1];
  endfunction
endpackage

// File: rtl/wh_rr_arb.sv
module wh_rr_arb #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx,
  output logic          gnt_any
);
  logic [IW-1:0] ptr_q;

  // Search begins at ptr_q and wraps around.
  always_comb begin
    int c;
    gnt     = '0;
    gnt_idx = '0;
    gnt_any = 1'b0;
    for (int k = 0; k < N; k++) begin
      c = int'(ptr_q) + k;
      if (c >= N) c = c - N;
      if (!gnt_any && req[c]) begin
        gnt_any = 1'b1;
        gnt[c]  = 1'b1;
        gnt_idx = IW'(c);
      end
    end
  end

  // After each grant, the winner gets the lowest priority.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (gnt_any) begin
      if (gnt_idx == IW'(N - 1)) ptr_q <= '0;
      else                       ptr_q <= gnt_idx + 1'b1;
    end
  end
endmodule

// File: rtl/wh_lock_state.sv
module wh_lock_state
  import wh_pkg::*;
#(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [IW-1:0] fire_idx,
  input  logic [1:0]    fire_kind,
  output logic [N-1:0]  owner,
  output logic          free
);
  // Updated when a flit enters the elastic buffer.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner <= '0;
      free  <= 1'b1;
    end else if (fire) begin
      if (free) begin
        // A single-flit packet claims and releases together, so nothing changes.
        if (fire_kind == FK_HEAD) begin
          owner[fire_idx] <= 1'b1;
          free            <= 1'b0;
        end
      end else if (kind_closes(fire_kind)) begin
        owner <= '0;
        free  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/wh_eb2.sv
module wh_eb2 #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data
);
  logic [W-1:0] slot_q [2];
  logic         wp_q, rp_q;
  logic [1:0]   cnt_q;
  logic         push, pop;

  assign s_ready = (cnt_q != 2'd2);
  assign m_valid = (cnt_q != 2'd0);
  assign m_data  = slot_q[rp_q];
  assign push    = s_valid & s_ready;
  assign pop     = m_valid & m_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= 1'b0;
      rp_q  <= 1'b0;
      cnt_q <= 2'd0;
    end else begin
      if (push) wp_q <= ~wp_q;
      if (pop)  rp_q <= ~rp_q;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 2'd1;
        2'b01:   cnt_q <= cnt_q - 2'd1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) slot_q[wp_q] <= s_data;
  end
endmodule

// File: rtl/wh_out_alloc.sv
module wh_out_alloc
  import wh_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int DATA_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_IN-1:0]              in_valid,
  output logic [N_IN-1:0]              in_ready,
  input  logic [N_IN*(DATA_W+2)-1:0]   in_flit,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [DATA_W+1:0]            out_flit
);
  localparam int FLIT_W = DATA_W + 2;
  localparam int IW     = (N_IN > 1) ? $clog2(N_IN) : 1;

  logic [FLIT_W-1:0] flit_a [N_IN];
  logic [1:0]        kind_a [N_IN];
  logic [N_IN-1:0]   req, gnt, owner;
  logic [IW-1:0]     gnt_idx;
  logic              gnt_any, free, eb_room;
  logic [FLIT_W-1:0] sel_flit;

  // Requests are qualified by buffer room and by ownership.
  for (genvar gi = 0; gi < N_IN; gi++) begin : g_req
    assign flit_a[gi] = in_flit[gi*FLIT_W +: FLIT_W];
    assign kind_a[gi] = flit_a[gi][FLIT_W-1 -: 2];
    assign req[gi]    = in_valid[gi] & eb_room &
                        (free ? kind_opens(kind_a[gi]) : owner[gi]);
  end

  wh_rr_arb #(.N(N_IN)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .gnt     (gnt),
    .gnt_idx (gnt_idx),
    .gnt_any (gnt_any)
  );

  wh_lock_state #(.N(N_IN)) u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (gnt_any),
    .fire_idx  (gnt_idx),
    .fire_kind (kind_a[gnt_idx]),
    .owner     (owner),
    .free      (free)
  );

  assign in_ready = gnt;
  assign sel_flit = flit_a[gnt_idx];

  wh_eb2 #(.W(FLIT_W)) u_eb (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (gnt_any),
    .s_ready (eb_room),
    .s_data  (sel_flit),
    .m_valid (out_valid),
    .m_ready (out_ready),
    .m_data  (out_flit)
  );
endmodule

// File: rtl/wh_out_alloc_chk.sv
module wh_out_alloc_chk
  import wh_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int DATA_W = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [N_IN-1:0]            in_valid,
  input logic [N_IN-1:0]            in_ready,
  input logic [N_IN*(DATA_W+2)-1:0] in_flit,
  input logic                       out_valid,
  input logic                       out_ready,
  input logic [DATA_W+1:0]          out_flit
);
  localparam int FLIT_W = DATA_W + 2;

  logic [N_IN-1:0] acc;
  logic            acc_any;
  logic [1:0]      acc_kind;
  logic [2:0]      occ_q;
  logic            owned_q;
  logic [N_IN-1:0] own_mask_q;

  assign acc     = in_valid & in_ready;
  assign acc_any = |acc;

  always_comb begin
    acc_kind = 2'b00;
    for (int i = 0; i < N_IN; i++)
      if (acc[i]) acc_kind = in_flit[i*FLIT_W + FLIT_W - 1 -: 2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q      <= '0;
      owned_q    <= 1'b0;
      own_mask_q <= '0;
    end else begin
      occ_q <= occ_q + {2'b00, acc_any} - {2'b00, out_valid & out_ready};
      if (acc_any) begin
        if (!owned_q && acc_kind == FK_HEAD) begin
          owned_q    <= 1'b1;
          own_mask_q <= acc;
        end else if (owned_q && kind_closes(acc_kind)) begin
          owned_q <= 1'b0;
        end
      end
    end
  end

  // R2
  onehot_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_ready));
  // R2
  ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready & ~in_valid) == '0);
  // R4
  owner_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    owned_q |-> ((in_ready & ~own_mask_q) == '0));
  // R5
  free_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!owned_q && acc_any) |-> kind_opens(acc_kind));
  // R8
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= 3'd2);
  // R8
  valid_tracks_occ_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == (occ_q != 3'd0));
  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_flit)));
endmodule

bind wh_out_alloc wh_out_alloc_chk #(.N_IN(N_IN), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_flit   (in_flit),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_flit  (out_flit)
);

// File: tb/test_wh_out_alloc.sv
module test_wh_out_alloc;
  import wh_pkg::*;

  localparam int N  = 4;
  localparam int DW = 8;
  localparam int FW = DW + 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    in_valid = '0;
  logic [N-1:0]    in_ready;
  logic [FW-1:0]   fl [N];
  logic [N*FW-1:0] in_flit;
  logic            out_valid;
  logic            out_ready = 1'b1;
  logic [FW-1:0]   out_flit;

  int n_tests = 0;
  int n_fail  = 0;
  logic [FW-1:0] got [$];

  always #4 clk = ~clk;

  always_comb
    for (int i = 0; i < N; i++) in_flit[i*FW +: FW] = fl[i];

  wh_out_alloc #(.N_IN(N), .DATA_W(DW)) i_wh_out_alloc (
    .clk, .rst_n, .in_valid, .in_ready, .in_flit,
    .out_valid, .out_ready, .out_flit
  );

  // Collect output transfers one nanosecond before each rising edge.
  initial forever begin
    @(negedge clk);
    #3;
    if (rst_n && out_valid && out_ready) got.push_back(out_flit);
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp_v, string what);
    n_tests++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp_v);
    end
  endtask

  // Called at a falling edge; returns at a falling edge once the flit has moved.
  task automatic send(int i, logic [1:0] k, logic [7:0] d, output int waited);
    logic ok;
    in_valid[i] = 1'b1;
    fl[i]       = {k, d};
    waited      = 0;
    forever begin
      #3;
      ok = in_ready[i];
      @(negedge clk);
      if (ok) break;
      waited++;
    end
    in_valid[i] = 1'b0;
  endtask

  task automatic expect_stream(string req, logic [FW-1:0] e [$]);
    repeat (4) @(negedge clk);
    chk(req, got.size(), e.size(), "stream length");
    for (int j = 0; j < e.size() && j < got.size(); j++)
      chk(req, got[j], e[j], $sformatf("flit %0d", j));
    got.delete();
  endtask

  task automatic do_reset();
    rst_n     = 1'b0;
    in_valid  = '0;
    out_ready = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    got.delete();
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk("R9", out_valid, 0, "out_valid after reset");
    chk("R9", in_ready, 0, "in_ready idle");
    in_valid = '1;
    for (int i = 0; i < N; i++) fl[i] = {FK_HEAD, 8'(i)};
    #1;
    chk("R9", in_ready, 4'b0001, "priority starts at input 0");
    in_valid = '0;
    @(negedge clk);
    repeat (3) @(negedge clk);
    do_reset();
  endtask

  task automatic t_packet();
    int w;
    send(2, FK_HEAD, 8'h11, w);
    send(2, FK_BODY, 8'h12, w); chk("R5", w, 0, "body accepted at once");
    send(2, FK_BODY, 8'h13, w); chk("R5", w, 0, "second body at once");
    send(2, FK_TAIL, 8'h14, w); chk("R5", w, 0, "tail at once");
    expect_stream("R10", '{{FK_HEAD, 8'h11}, {FK_BODY, 8'h12},
                           {FK_BODY, 8'h13}, {FK_TAIL, 8'h14}});
  endtask

  task automatic t_ignore();
    in_valid[1] = 1'b1;
    fl[1]       = {FK_BODY, 8'hEE};
    repeat (3) begin
      #1;
      chk("R5", in_ready, 0, "body offered while free");
      @(negedge clk);
    end
    chk("R5", out_valid, 0, "nothing forwarded");
    in_valid[1] = 1'b0;
  endtask

  task automatic t_lock();
    int w;
    send(0, FK_HEAD, 8'h21, w);
    in_valid[1] = 1'b1;
    fl[1]       = {FK_HEAD, 8'h31};
    repeat (2) begin
      #1;
      chk("R4", in_ready[1], 0, "other head masked");
      @(negedge clk);
    end
    send(0, FK_BODY, 8'h22, w); chk("R4", w, 0, "owner body passes");
    send(0, FK_TAIL, 8'h23, w);
    #1;
    chk("R6", in_ready[1], 1, "waiting head wins after tail");
    @(negedge clk);
    in_valid[1] = 1'b0;
    send(1, FK_TAIL, 8'h32, w);
    expect_stream("R4", '{{FK_HEAD, 8'h21}, {FK_BODY, 8'h22}, {FK_TAIL, 8'h23},
                          {FK_HEAD, 8'h31}, {FK_TAIL, 8'h32}});
  endtask

  task automatic t_rr();
    do_reset();
    fork
      begin int w; send(0, FK_SOLO, 8'h41, w); send(0, FK_SOLO, 8'h42, w); end
      begin int w; send(2, FK_SOLO, 8'h61, w); send(2, FK_SOLO, 8'h62, w); end
    join
    expect_stream("R3", '{{FK_SOLO, 8'h41}, {FK_SOLO, 8'h61},
                          {FK_SOLO, 8'h42}, {FK_SOLO, 8'h62}});
  endtask

  task automatic t_hold();
    do_reset();
    fork
      begin
        int w;
        send(1, FK_HEAD, 8'h51, w);
        send(1, FK_BODY, 8'h52, w);
        send(1, FK_TAIL, 8'h53, w);
      end
      begin
        @(negedge clk);
        fork
          begin int w; send(0, FK_SOLO, 8'h01, w); end
          begin int w; send(3, FK_SOLO, 8'h71, w); end
        join
      end
    join
    expect_stream("R7", '{{FK_HEAD, 8'h51}, {FK_BODY, 8'h52}, {FK_TAIL, 8'h53},
                          {FK_SOLO, 8'h71}, {FK_SOLO, 8'h01}});
  endtask

  task automatic t_solo();
    int w;
    send(1, FK_SOLO, 8'h81, w);
    send(3, FK_HEAD, 8'h91, w);
    chk("R6", w, 0, "head right after single flit");
    send(3, FK_TAIL, 8'h92, w);
    expect_stream("R6", '{{FK_SOLO, 8'h81}, {FK_HEAD, 8'h91}, {FK_TAIL, 8'h92}});
  endtask

  task automatic t_bp();
    out_ready = 1'b0;
    fork
      begin
        int w;
        send(2, FK_SOLO, 8'hA1, w);
        send(2, FK_SOLO, 8'hA2, w);
        send(2, FK_SOLO, 8'hA3, w);
      end
    join_none
    repeat (5) @(negedge clk);
    #1;
    chk("R1", in_ready[2], 0, "head blocked with buffer full");
    chk("R8", out_valid, 1, "out_valid while held");
    chk("R8", out_flit, {FK_SOLO, 8'hA1}, "oldest flit presented");
    out_ready = 1'b1;
    wait fork;
    expect_stream("R8", '{{FK_SOLO, 8'hA1}, {FK_SOLO, 8'hA2}, {FK_SOLO, 8'hA3}});
  endtask

  function automatic void summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endfunction

  initial begin
    #(8 * 20000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) fl[i] = '0;
    @(negedge clk);
    t_reset();
    t_packet();
    t_ignore();
    t_lock();
    t_rr();
    t_hold();
    t_solo();
    t_bp();
    summary();
    $finish;
  end
endmodule